// File: doc/BRIEF.md
# Sleep, Halt and Wakeup Power-State Controller

This block decides when the processor clock, the peripheral clocks and the analog supports of a small USB controller chip may run. Software writes a 16-bit control word. One command bit puts the whole chip to sleep: the peripheral clock gate closes and the PLL, the supply booster, the VBUS charge pump and the USB transceivers are all told to power down. Another command bit only halts the processor: its clock enable drops while every peripheral, clock and analog block keeps running. Writing a zero to either command bit does nothing.

Sleep ends on any wake event whose enable bit is set in the same control word. The event sources are activity on either USB port, a change on OTG VBUS-valid or on the ID line, any transition on the high-speed serial receive line, a falling edge on the SPI slave select, a host-port read, and a transition on either of two GPIO inputs. After a sleep wake the analog blocks power up at once. The clocks stay gated for a programmable number of PLL-settle cycles, and then the processor resumes. A wake that does not come only from USB port activity raises a one-cycle wake interrupt. A wake caused by the serial receive line or the SPI select raises a one-cycle pulse that tells the serial logic to drop the byte in flight. Halt ends on the cycle after any enabled interrupt is pending.

The controller is a four-state machine. RUN is the normal state. The transition *enter_sleep* goes from RUN to SLEEP. The transition *enter_halt* goes from RUN to HALT. The transition *wake_hit* goes from SLEEP to SETTLE. The transition *settle_done* goes from SETTLE back to RUN. The transition *irq_resume* goes from HALT back to RUN. A power-on reset returns the machine to RUN.

Top module: `pwr_state_ctrl`

## Requirements
- R1: After reset the state is RUN. cpu_clk_en and periph_clk_en are 1, all four power-down outputs are 0, wake_irq and byte_drop are 0, and reg_rdata is 0 apart from bit 2.
- R2: A write in RUN with bit 1 set moves to SLEEP on the next edge. In SLEEP, cpu_clk_en and periph_clk_en are 0, pll_pd, boost_pd, pump_pd and xcvr_pd are 1, and reg_rdata bit 1 reads 1.
- R3: A write in RUN with bit 0 set and bit 1 clear moves to HALT. In HALT only cpu_clk_en is 0, and reg_rdata bit 0 reads 1. If bits 1 and 0 are both set, sleep wins.
- R4: The wake-enable bits are 14 (port 2 activity), 12 (port 1 activity), 11 (VBUS-valid or ID change), 9 (serial RX transition), 8 (SPI select fall), 7 (host-port read) and 4 (GPIO pair transition). They are stored on every write and read back in place. Bit 2 reads the boost_low input, where 1 means the rails are low. Bits 15, 13, 10, 6, 5 and 3 read 0. Writing 0 to bits 1 and 0 leaves the state unchanged.
- R5: SLEEP is left only on an event whose enable bit is set. An event with its enable clear leaves the block asleep.
- R6: The SPI select wakes the block only on a falling edge. The serial RX line, the two GPIO inputs, VBUS-valid and ID wake it on either edge. Port activity and host-port reads wake it while high. The edge detectors start from idle levels: ID, RX and select high, VBUS-valid and GPIO low.
- R7: After a wake, the block is in SETTLE for settle_cycles+1 cycles. In SETTLE all power-down outputs are 0 while both clocks stay gated. The block is then in RUN with both clocks enabled.
- R8: HALT is left on the cycle after irq_pend is 1. Wake events do not end HALT, and irq_pend does not end SLEEP.
- R9: wake_irq is 1 for exactly the first SETTLE cycle when a non-port source took part in the wake. It stays 0 for a wake caused only by port activity.
- R10: byte_drop is 1 for exactly the first SETTLE cycle when the serial RX or SPI select source took part in the wake.
- R11: The sleep and halt read bits clear when the block returns to RUN. Command bits written outside RUN are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-on clock |
| rst_n | input | 1 | Active-low reset |
| reg_wr | input | 1 | Control word write strobe |
| reg_wdata | input | 16 | Control word write data |
| reg_rdata | output | 16 | Control word read value |
| boost_low | input | 1 | Booster status, 1 = rails below threshold |
| settle_cycles | input | SETTLE_W | PLL-settle count used after a sleep wake |
| port1_act | input | 1 | USB port 1 activity |
| port2_act | input | 1 | USB port 2 activity |
| vbus_ok | input | 1 | OTG VBUS-valid level |
| otg_id | input | 1 | OTG ID level |
| hss_rx | input | 1 | High-speed serial receive line |
| spi_ss_n | input | 1 | SPI slave select, active low |
| hpi_rd | input | 1 | Host-port read strobe |
| gpio_wk | input | 2 | Two GPIO wake inputs |
| irq_pend | input | 1 | Some enabled interrupt is pending |
| cpu_clk_en | output | 1 | Processor clock enable |
| periph_clk_en | output | 1 | Peripheral clock gate enable |
| pll_pd | output | 1 | PLL power-down |
| boost_pd | output | 1 | Booster power-down |
| pump_pd | output | 1 | Charge pump power-down |
| xcvr_pd | output | 1 | USB transceiver power-down |
| wake_irq | output | 1 | One-cycle wake interrupt |
| byte_drop | output | 1 | One-cycle request to discard the waking serial byte |

## Verification
The state register shows at the ports directly: the two clock enables, the four power-down lines and read bits 1 and 0 together give a distinct pattern for each state. A wrong state therefore shows up on the first cycle after the faulty transition. Two kinds of fault stay hidden until a wake happens: a mis-stored enable bit, and an edge detector that holds the wrong previous value. Each one shows on the cycle after the stimulus, as a missing or extra move into SETTLE. A wrong settle count shows only at the end of SETTLE, when cpu_clk_en returns one or more cycles early or late.

// File: rtl/pwr_pkg.sv
package pwr_pkg;
    localparam int unsigned REG_W = 16;

    typedef enum logic [1:0] {
        ST_RUN    = 2'd0,
        ST_HALT   = 2'd1,
        ST_SLEEP  = 2'd2,
        ST_SETTLE = 2'd3
    } pstate_t;

    // control word bit positions (software visible)
    localparam int unsigned B_P2    = 14;
    localparam int unsigned B_P1    = 12;
    localparam int unsigned B_OTG   = 11;
    localparam int unsigned B_HSS   = 9;
    localparam int unsigned B_SPI   = 8;
    localparam int unsigned B_HPI   = 7;
    localparam int unsigned B_GPI   = 4;
    localparam int unsigned B_BOOST = 2;
    localparam int unsigned B_SLEEP = 1;
    localparam int unsigned B_HALT  = 0;

    localparam logic [REG_W-1:0] WAKE_MASK   = 16'h5B90;
    localparam logic [REG_W-1:0] PORT_MASK   = 16'h5000;
    localparam logic [REG_W-1:0] SERIAL_MASK = 16'h0300;
endpackage

// File: rtl/pwr_wake_detect.sv
module pwr_wake_detect
    import pwr_pkg::*;
#(
    parameter int unsigned GPIO_N = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              port1_act,
    input  logic              port2_act,
    input  logic              vbus_ok,
    input  logic              otg_id,
    input  logic              hss_rx,
    input  logic              spi_ss_n,
    input  logic              hpi_rd,
    input  logic [GPIO_N-1:0] gpio_wk,
    output logic [REG_W-1:0]  evt
);
    logic              vbus_q, id_q, rx_q, ss_q;
    logic [GPIO_N-1:0] gpio_q;

    // previous levels, reset to the idle level of each line
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            vbus_q <= 1'b0;
            id_q   <= 1'b1;
            rx_q   <= 1'b1;
            ss_q   <= 1'b1;
            gpio_q <= '0;
        end else begin
            vbus_q <= vbus_ok;
            id_q   <= otg_id;
            rx_q   <= hss_rx;
            ss_q   <= spi_ss_n;
            gpio_q <= gpio_wk;
        end
    end

    // event vector aligned with the enable bits of the control word
    always_comb begin
        evt        = '0;
        evt[B_P2]  = port2_act;
        evt[B_P1]  = port1_act;
        evt[B_OTG] = (vbus_ok ^ vbus_q) | (otg_id ^ id_q);
        evt[B_HSS] = hss_rx ^ rx_q;
        evt[B_SPI] = ss_q & ~spi_ss_n;
        evt[B_HPI] = hpi_rd;
        evt[B_GPI] = |(gpio_wk ^ gpio_q);
    end
endmodule

// File: rtl/pwr_settle_timer.sv
module pwr_settle_timer #(
    parameter int unsigned W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic         done
);
    logic [W-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)          cnt <= '0;
        else if (load)       cnt <= load_val;
        else if (cnt != '0)  cnt <= cnt - 1'b1;
    end

    assign done = (cnt == '0);
endmodule

// File: rtl/pwr_state_ctrl.sv
module pwr_state_ctrl
    import pwr_pkg::*;
#(
    parameter int unsigned SETTLE_W = 8,
    parameter int unsigned GPIO_N   = 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                reg_wr,
    input  logic [15:0]         reg_wdata,
    output logic [15:0]         reg_rdata,
    input  logic                boost_low,
    input  logic [SETTLE_W-1:0] settle_cycles,
    input  logic                port1_act,
    input  logic                port2_act,
    input  logic                vbus_ok,
    input  logic                otg_id,
    input  logic                hss_rx,
    input  logic                spi_ss_n,
    input  logic                hpi_rd,
    input  logic [GPIO_N-1:0]   gpio_wk,
    input  logic                irq_pend,
    output logic                cpu_clk_en,
    output logic                periph_clk_en,
    output logic                pll_pd,
    output logic                boost_pd,
    output logic                pump_pd,
    output logic                xcvr_pd,
    output logic                wake_irq,
    output logic                byte_drop
);
    pstate_t          state, state_nx;
    logic [REG_W-1:0] wake_en;
    logic [REG_W-1:0] evt;
    logic [REG_W-1:0] hit;
    logic             wake_any, settle_done, start_settle;

    pwr_wake_detect #(.GPIO_N(GPIO_N)) u_detect (
        .clk       (clk),
        .rst_n     (rst_n),
        .port1_act (port1_act),
        .port2_act (port2_act),
        .vbus_ok   (vbus_ok),
        .otg_id    (otg_id),
        .hss_rx    (hss_rx),
        .spi_ss_n  (spi_ss_n),
        .hpi_rd    (hpi_rd),
        .gpio_wk   (gpio_wk),
        .evt       (evt)
    );

    assign hit          = evt & wake_en;
    assign wake_any     = |hit;
    assign start_settle = (state == ST_SLEEP) && wake_any;

    pwr_settle_timer #(.W(SETTLE_W)) u_settle (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (start_settle),
        .load_val (settle_cycles),
        .done     (settle_done)
    );

    // wake-enable storage: updated by every write, in any state
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      wake_en <= '0;
        else if (reg_wr) wake_en <= reg_wdata & WAKE_MASK;
    end

    // next-state logic
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_RUN: begin
                if (reg_wr && reg_wdata[B_SLEEP])     state_nx = ST_SLEEP;  // enter_sleep
                else if (reg_wr && reg_wdata[B_HALT]) state_nx = ST_HALT;   // enter_halt
            end
            ST_HALT:   if (irq_pend)    state_nx = ST_RUN;                  // irq_resume
            ST_SLEEP:  if (wake_any)    state_nx = ST_SETTLE;               // wake_hit
            ST_SETTLE: if (settle_done) state_nx = ST_RUN;                  // settle_done
        endcase
    end

    // state register and one-cycle wake pulses
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state     <= ST_RUN;
            wake_irq  <= 1'b0;
            byte_drop <= 1'b0;
        end else begin
            state     <= state_nx;
            wake_irq  <= start_settle && |(hit & ~PORT_MASK);
            byte_drop <= start_settle && |(hit & SERIAL_MASK);
        end
    end

    // outputs decoded from the state
    always_comb begin
        cpu_clk_en    = 1'b0;
        periph_clk_en = 1'b1;
        pll_pd        = 1'b0;
        boost_pd      = 1'b0;
        pump_pd       = 1'b0;
        xcvr_pd       = 1'b0;
        unique case (state)
            ST_RUN:    cpu_clk_en = 1'b1;
            ST_HALT:   cpu_clk_en = 1'b0;
            ST_SLEEP: begin
                periph_clk_en = 1'b0;
                pll_pd        = 1'b1;
                boost_pd      = 1'b1;
                pump_pd       = 1'b1;
                xcvr_pd       = 1'b1;
            end
            ST_SETTLE: periph_clk_en = 1'b0;
        endcase
    end

    always_comb begin
        reg_rdata          = wake_en;
        reg_rdata[B_BOOST] = boost_low;
        reg_rdata[B_SLEEP] = (state == ST_SLEEP) || (state == ST_SETTLE);
        reg_rdata[B_HALT]  = (state == ST_HALT);
    end
endmodule

// File: rtl/pwr_state_ctrl_chk.sv
module pwr_state_ctrl_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        reg_wr,
    input logic [15:0] reg_wdata,
    input logic [15:0] reg_rdata,
    input logic        irq_pend,
    input logic        cpu_clk_en,
    input logic        periph_clk_en,
    input logic        pll_pd,
    input logic        xcvr_pd,
    input logic        wake_irq,
    input logic        byte_drop
);
    p_sleep_entry_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_wdata[1] && reg_rdata[1:0] == 2'b00) |=> (xcvr_pd && !cpu_clk_en && !periph_clk_en));

    p_halt_periph_r3: assert property (@(posedge clk) disable iff (!rst_n)
        reg_rdata[0] |-> (periph_clk_en && !cpu_clk_en && !pll_pd));

    p_no_enable_stays_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (pll_pd && (reg_rdata & 16'h5B90) == 16'h0000 && !reg_wr) |=> pll_pd);

    p_halt_exit_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_rdata[0] && irq_pend) |=> cpu_clk_en);

    p_irq_in_settle_r9: assert property (@(posedge clk) disable iff (!rst_n)
        wake_irq |-> (!pll_pd && !cpu_clk_en && reg_rdata[1]));

    p_drop_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
        byte_drop |=> !byte_drop);

    p_run_clear_r11: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_clk_en |-> (reg_rdata[1:0] == 2'b00));
endmodule

bind pwr_state_ctrl pwr_state_ctrl_chk u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .reg_wr        (reg_wr),
    .reg_wdata     (reg_wdata),
    .reg_rdata     (reg_rdata),
    .irq_pend      (irq_pend),
    .cpu_clk_en    (cpu_clk_en),
    .periph_clk_en (periph_clk_en),
    .pll_pd        (pll_pd),
    .xcvr_pd       (xcvr_pd),
    .wake_irq      (wake_irq),
    .byte_drop     (byte_drop)
);

// File: tb/pwr_state_ctrl_tb.sv
`timescale 1ns/1ps
module pwr_state_ctrl_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic [15:0] reg_wdata = '0;
    logic [15:0] reg_rdata;
    logic        boost_low = 1'b0;
    logic [7:0]  settle_cycles = 8'd3;
    logic        port1_act = 1'b0, port2_act = 1'b0, vbus_ok = 1'b0, otg_id = 1'b1;
    logic        hss_rx = 1'b1, spi_ss_n = 1'b1, hpi_rd = 1'b0, irq_pend = 1'b0;
    logic [1:0]  gpio_wk = 2'b00;
    logic        cpu_clk_en, periph_clk_en, pll_pd, boost_pd, pump_pd, xcvr_pd, wake_irq, byte_drop;

    int total = 0;
    int bad = 0;
    bit finished = 1'b0;

    always #10 clk = ~clk;

    pwr_state_ctrl u_dut (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .boost_low(boost_low), .settle_cycles(settle_cycles),
        .port1_act(port1_act), .port2_act(port2_act), .vbus_ok(vbus_ok), .otg_id(otg_id),
        .hss_rx(hss_rx), .spi_ss_n(spi_ss_n), .hpi_rd(hpi_rd), .gpio_wk(gpio_wk), .irq_pend(irq_pend),
        .cpu_clk_en(cpu_clk_en), .periph_clk_en(periph_clk_en), .pll_pd(pll_pd), .boost_pd(boost_pd),
        .pump_pd(pump_pd), .xcvr_pd(xcvr_pd), .wake_irq(wake_irq), .byte_drop(byte_drop)
    );

    // behavioural reference: 0 run, 1 halt, 2 sleep, 3 settle
    int          m_mode = 0;
    int          m_cnt = 0;
    logic [15:0] m_en = '0;
    bit          m_irq = 0, m_drop = 0;
    bit          pv_vbus = 0, pv_id = 1, pv_rx = 1, pv_ss = 1;
    logic [1:0]  pv_gpio = 2'b00;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_mode = 0; m_cnt = 0; m_en = '0; m_irq = 0; m_drop = 0;
            pv_vbus = 0; pv_id = 1; pv_rx = 1; pv_ss = 1; pv_gpio = 2'b00;
        end else begin
            bit h_p2, h_p1, h_otg, h_rx, h_ss, h_rd, h_gp;
            h_p2  = port2_act && m_en[14];
            h_p1  = port1_act && m_en[12];
            h_otg = ((vbus_ok != pv_vbus) || (otg_id != pv_id)) && m_en[11];
            h_rx  = (hss_rx != pv_rx) && m_en[9];
            h_ss  = (pv_ss && !spi_ss_n) && m_en[8];
            h_rd  = hpi_rd && m_en[7];
            h_gp  = (gpio_wk != pv_gpio) && m_en[4];
            m_irq = 0; m_drop = 0;
            case (m_mode)
                0: if (reg_wr && reg_wdata[1]) m_mode = 2;
                   else if (reg_wr && reg_wdata[0]) m_mode = 1;
                1: if (irq_pend) m_mode = 0;
                2: if (h_p2 || h_p1 || h_otg || h_rx || h_ss || h_rd || h_gp) begin
                       m_mode = 3;
                       m_cnt  = settle_cycles;
                       m_irq  = h_otg || h_rx || h_ss || h_rd || h_gp;
                       m_drop = h_rx || h_ss;
                   end
                default: if (m_cnt == 0) m_mode = 0; else m_cnt = m_cnt - 1;
            endcase
            if (reg_wr) m_en = reg_wdata & 16'h5B90;
            pv_vbus = vbus_ok; pv_id = otg_id; pv_rx = hss_rx; pv_ss = spi_ss_n; pv_gpio = gpio_wk;
        end
    end

    task automatic chk(string tag, int act, int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s act=%0h exp=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    // per-cycle comparison against the reference
    always begin
        @(negedge clk);
        #1;
        if (rst_n && !finished) begin
            logic [15:0] er;
            er = m_en;
            er[2] = boost_low;
            er[1] = (m_mode >= 2);
            er[0] = (m_mode == 1);
            chk("R7 cpu_clk_en", cpu_clk_en, m_mode == 0);
            chk("R2 periph_clk_en", periph_clk_en, m_mode < 2);
            chk("R2 pd group", {pll_pd, boost_pd, pump_pd, xcvr_pd}, (m_mode == 2) ? 4'hF : 4'h0);
            chk("R4 reg_rdata", reg_rdata, er);
            chk("R9 wake_irq", wake_irq, m_irq);
            chk("R10 byte_drop", byte_drop, m_drop);
        end
    end

    task automatic cyc(int n = 1);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(logic [15:0] d);
        reg_wr = 1'b1; reg_wdata = d;
        cyc();
        reg_wr = 1'b0; reg_wdata = '0;
    endtask

    initial begin
        cyc(3);
        rst_n = 1'b1;
        cyc();
        chk("R1 rdata after reset", reg_rdata, 16'h0000);
        chk("R1 cpu clock after reset", cpu_clk_en, 1);
        chk("R1 pll after reset", pll_pd, 0);

        boost_low = 1'b1;
        #1 chk("R4 boost status", reg_rdata[2], 1);
        wr(16'hFFFC);
        chk("R4 enables stored, reserved zero", reg_rdata, 16'h5B94);
        chk("R4 zero command bits keep RUN", cpu_clk_en, 1);
        boost_low = 1'b0;

        // SPI-select wake, settle of 3
        spi_ss_n = 1'b0;
        cyc();
        wr(16'h0102);
        chk("R2 sleep clocks", {cpu_clk_en, periph_clk_en}, 0);
        chk("R2 sleep power-down", {pll_pd, boost_pd, pump_pd, xcvr_pd}, 4'hF);
        chk("R2 sleep read bit", reg_rdata[1], 1);
        hss_rx = 1'b0; cyc();
        chk("R5 disabled RX edge stays asleep", pll_pd, 1);
        spi_ss_n = 1'b1; cyc();
        chk("R6 select rise ignored", pll_pd, 1);
        irq_pend = 1'b1; cyc(); irq_pend = 1'b0;
        chk("R8 irq does not end sleep", pll_pd, 1);
        wr(16'h0101);
        chk("R11 halt write in sleep ignored", reg_rdata[1:0], 2'b10);
        spi_ss_n = 1'b0; cyc();
        chk("R7 settle power up", {pll_pd, xcvr_pd, cpu_clk_en}, 0);
        chk("R9 irq on select wake", wake_irq, 1);
        chk("R10 drop on select wake", byte_drop, 1);
        cyc();
        chk("R10 drop one cycle", byte_drop, 0);
        cyc(2);
        chk("R7 clocks still gated", cpu_clk_en, 0);
        cyc();
        chk("R7 run after settle", cpu_clk_en, 1);
        chk("R11 sleep bit cleared", reg_rdata[1:0], 2'b00);

        // port-only wake, settle 0
        settle_cycles = 8'd0;
        wr(16'h4002);
        port1_act = 1'b1; cyc(); port1_act = 1'b0;
        chk("R5 disabled port 1 ignored", pll_pd, 1);
        port2_act = 1'b1; cyc(); port2_act = 1'b0;
        chk("R9 no irq for port wake", wake_irq, 0);
        chk("R7 settle entered", pll_pd, 0);
        cyc();
        chk("R7 zero settle gives run", cpu_clk_en, 1);

        // halt
        wr(16'h4001);
        chk("R3 halt keeps periph", {cpu_clk_en, periph_clk_en, pll_pd}, 3'b010);
        chk("R3 halt read bit", reg_rdata[1:0], 2'b01);
        port2_act = 1'b1; cyc(); port2_act = 1'b0;
        chk("R8 wake event keeps halt", cpu_clk_en, 0);
        irq_pend = 1'b1; cyc(); irq_pend = 1'b0;
        chk("R8 irq resumes", cpu_clk_en, 1);
        chk("R11 halt bit cleared", reg_rdata[0], 0);

        // both bits: sleep wins, GPIO wake
        settle_cycles = 8'd2;
        wr(16'h0013);
        chk("R3 sleep has priority", reg_rdata[1:0], 2'b10);
        gpio_wk = 2'b10; cyc();
        chk("R6 GPIO edge wakes", pll_pd, 0);
        chk("R10 no drop on GPIO wake", byte_drop, 0);
        chk("R9 irq on GPIO wake", wake_irq, 1);
        cyc(3);

        // OTG ID edge and RX edge, then host read
        wr(16'h0802);
        otg_id = 1'b0; cyc();
        chk("R6 ID edge wakes", pll_pd, 0);
        cyc(3);
        wr(16'h0202);
        hss_rx = 1'b1; cyc();
        chk("R10 drop on RX wake", byte_drop, 1);
        cyc(3);
        wr(16'h0082);
        hpi_rd = 1'b1; cyc(); hpi_rd = 1'b0;
        chk("R6 host read wakes", pll_pd, 0);
        cyc(4);

        finished = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            total++; bad++;
            $display("FAIL R1 watchdog act=0 exp=1");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule